// File: doc/BRIEF.md
# Serial Configuration Loader

This block brings up a downstream programmable device through its slave-serial configuration port. A start request switches on the target's power enable and waits a settling interval. It then pulls the active-low program line for a fixed number of cycles and releases it. Next it waits a bounded time for the target to raise its init-ready input. Image bytes then arrive over a valid/ready byte stream and are shifted out most significant bit first on a data line, with a divided configuration clock. After the last byte, the block keeps pulsing the configuration clock until the target raises its done input, and it gives up after a bounded number of pulses.

The bytes can go out in their natural order. They can also go out with the order reversed inside each 32-bit word: stream bytes are gathered into a four-entry buffer and read back at address `index ^ 3`. Reversal is refused when the image offset is not word aligned or the length is not a whole number of words. A refused request, an init timeout and a done timeout all end in the same error status. A successful load ends in an ok status. Either status stays until the next accepted start.

Top module: `cfg_loader`

## Requirements
- R1: After reset, pwr_en_o=0, prog_n_o=1, cclk_o=0, din_o=0, busy_o=0, ok_o=0, err_o=0. Whenever busy_o is low, cclk_o is low.
- R2: An accepted start raises pwr_en_o in the next cycle. prog_n_o goes low after SETTLE_CYC cycles and stays low for exactly PROG_LOW_CYC cycles. prog_n_o is never low while pwr_en_o is low.
- R3: If the synchronised init_i stays low for INIT_LIMIT cycles after prog_n_o returns high, the block ends with err_o=1. It sends no configuration clock pulse and takes no byte (byte_ready_o never accepted).
- R4: Each byte is sent MSB first, one bit per configuration clock pulse. din_o changes only while cclk_o is low and is stable across each rising edge. Each clock half-period lasts HALF_CYC system cycles.
- R5: With rev_i=0, bytes go out in stream order for any length, including lengths that are not a multiple of 4.
- R6: With rev_i=1, stream byte k goes out in position k^3, which gives the order 3,2,1,0,7,6,5,4 and so on.
- R7: A start with rev_i=1 and either img_ofs_i (image start address bits [1:0]) nonzero or img_len_i[1:0] nonzero ends at once with err_o=1. No byte is taken and no clock pulse is sent.
- R8: After the last byte, the block issues clock pulses (high, then low) until the synchronised done_i is high. It then ends with ok_o=1 and busy_o=0.
- R9: If done_i stays low, the block issues exactly DONE_LIMIT trailing pulses and then ends with err_o=1.
- R10: start_i is ignored while busy_o is high. The running load is not altered.
- R11: ok_o and err_o hold until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, one cycle |
| rev_i | input | 1 | 1 = reverse byte order within each 32-bit word |
| img_ofs_i | input | 2 | Low two address bits of the image start |
| img_len_i | input | LEN_W | Image length in bytes |
| byte_valid_i | input | 1 | Stream byte valid |
| byte_data_i | input | 8 | Stream byte |
| byte_ready_o | output | 1 | Block accepts a stream byte |
| init_i | input | 1 | Target init-ready, active high, asynchronous |
| done_i | input | 1 | Target done, active high, asynchronous |
| pwr_en_o | output | 1 | Target power enable |
| prog_n_o | output | 1 | Program line, active low |
| cclk_o | output | 1 | Configuration clock |
| din_o | output | 1 | Configuration data |
| busy_o | output | 1 | Load in progress |
| ok_o | output | 1 | Last load succeeded |
| err_o | output | 1 | Last load failed |

## Verification
Some properties are checked by assertions on every cycle. The data line never changes while the configuration clock is high and never changes on its rising edge. The configuration clock is idle whenever the block is not busy. The program line is low only with power on. A held error survives until a start, and the trailing-pulse counter stays within its limit. Other behaviour shows only in the bench's directed scenarios: the byte order seen by a target model in both modes, the exact program-pulse width and the clock half-period. The same goes for the two timeout paths with their pulse counts, the refusal of misaligned reversal, and a start that is ignored mid-load.

// File: rtl/cfg_pkg.sv
`timescale 1ns/1ps
package cfg_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_SETTLE,
    S_PROG,
    S_INIT_WAIT,
    S_FILL,
    S_SEND,
    S_TRAIL,
    S_OK,
    S_ERR
  } cfg_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/cfg_sync2.sv
`timescale 1ns/1ps
module cfg_sync2 #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q;
  logic [W-1:0] sync_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/cfg_serial.sv
`timescale 1ns/1ps
module cfg_serial #(
  parameter int HALF_CYC = 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic       pulse_i,
  input  logic [7:0] data_i,
  output logic       idle_o,
  output logic       cclk_o,
  output logic       din_o
);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic          active_q;
  logic          hi_q;
  logic          din_q;
  logic [6:0]    sh_q;
  logic [3:0]    bits_q;
  logic [HW-1:0] cnt_q;
  logic          half_end;

  assign half_end = (cnt_q == HW'(HALF_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      hi_q     <= 1'b0;
      din_q    <= 1'b0;
      sh_q     <= '0;
      bits_q   <= '0;
      cnt_q    <= '0;
    end else if (!active_q) begin
      if (load_i || pulse_i) begin
        active_q <= 1'b1;
        hi_q     <= 1'b0;
        cnt_q    <= '0;
        bits_q   <= load_i ? 4'd8 : 4'd1;
        din_q    <= load_i ? data_i[7] : 1'b0;
        sh_q     <= data_i[6:0];
      end
    end else if (half_end) begin
      cnt_q <= '0;
      if (!hi_q) begin
        hi_q <= 1'b1;
      end else begin
        hi_q   <= 1'b0;
        bits_q <= bits_q - 4'd1;
        if (bits_q == 4'd1) begin
          active_q <= 1'b0;
        end else begin
          din_q <= sh_q[6];
          sh_q  <= {sh_q[5:0], 1'b0};
        end
      end
    end else begin
      cnt_q <= cnt_q + HW'(1);
    end
  end

  assign idle_o = !active_q;
  assign cclk_o = hi_q;
  assign din_o  = din_q;

  // R4: data moves only while the clock is low
  p_din_low_r4: assert property (@(posedge clk) disable iff (rst)
    !$stable(din_q) |-> !hi_q);
  // R4: data is held across each rising clock edge
  p_din_hold_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(hi_q) |-> $stable(din_q));
endmodule

// File: rtl/cfg_loader.sv
`timescale 1ns/1ps
module cfg_loader import cfg_pkg::*; #(
  parameter int SETTLE_CYC   = 2500000,
  parameter int PROG_LOW_CYC = 2500000,
  parameter int INIT_LIMIT   = 100000,
  parameter int DONE_LIMIT   = 100000,
  parameter int HALF_CYC     = 1,
  parameter int LEN_W        = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             rev_i,
  input  logic [1:0]       img_ofs_i,
  input  logic [LEN_W-1:0] img_len_i,
  input  logic             byte_valid_i,
  input  logic [7:0]       byte_data_i,
  output logic             byte_ready_o,
  input  logic             init_i,
  input  logic             done_i,
  output logic             pwr_en_o,
  output logic             prog_n_o,
  output logic             cclk_o,
  output logic             din_o,
  output logic             busy_o,
  output logic             ok_o,
  output logic             err_o
);
  localparam int TMR_MAX = imax(imax(SETTLE_CYC, PROG_LOW_CYC), imax(INIT_LIMIT, DONE_LIMIT));
  localparam int TMR_W   = $clog2(TMR_MAX + 1);

  cfg_state_e       state_q;
  logic [TMR_W-1:0] tmr_q;
  logic [LEN_W-1:0] rem_q;
  logic             rev_q;
  logic             pwr_q;
  logic [1:0]       fill_q;
  logic [1:0]       send_q;
  logic [2:0]       grp_q;
  logic [7:0]       buf_mem [4];

  logic init_s, done_s;
  logic ser_idle, ser_load, ser_pulse;
  logic misalign;
  logic [1:0] rd_addr;
  logic last_in_grp;

  cfg_sync2 #(.W(2)) i_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({init_i, done_i}),
    .q_o ({init_s, done_s})
  );

  assign misalign    = rev_i && ((img_ofs_i != 2'd0) || (img_len_i[1:0] != 2'd0));
  assign rd_addr     = rev_q ? (send_q ^ 2'b11) : send_q;
  assign last_in_grp = ({1'b0, send_q} == (grp_q - 3'd1));
  assign ser_load    = (state_q == S_SEND) && ser_idle;
  assign ser_pulse   = (state_q == S_TRAIL) && ser_idle && !done_s &&
                       (tmr_q != TMR_W'(DONE_LIMIT));

  // four-byte group buffer, synchronous write, addressed read
  always_ff @(posedge clk) begin
    if (state_q == S_FILL && byte_valid_i) begin
      buf_mem[fill_q] <= byte_data_i;
    end
  end

  cfg_serial #(.HALF_CYC(HALF_CYC)) i_serial (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ser_load),
    .pulse_i (ser_pulse),
    .data_i  (buf_mem[rd_addr]),
    .idle_o  (ser_idle),
    .cclk_o  (cclk_o),
    .din_o   (din_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      tmr_q   <= '0;
      rem_q   <= '0;
      rev_q   <= 1'b0;
      pwr_q   <= 1'b0;
      fill_q  <= '0;
      send_q  <= '0;
      grp_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_OK, S_ERR: begin
          if (start_i) begin
            if (misalign) begin
              state_q <= S_ERR;
            end else begin
              state_q <= S_SETTLE;
              pwr_q   <= 1'b1;
              tmr_q   <= '0;
              rev_q   <= rev_i;
              rem_q   <= img_len_i;
            end
          end
        end
        S_SETTLE: begin
          if (tmr_q == TMR_W'(SETTLE_CYC - 1)) begin
            state_q <= S_PROG;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        S_PROG: begin
          if (tmr_q == TMR_W'(PROG_LOW_CYC - 1)) begin
            state_q <= S_INIT_WAIT;
            tmr_q   <= '0;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        S_INIT_WAIT: begin
          if (init_s) begin
            fill_q  <= '0;
            tmr_q   <= '0;
            state_q <= (rem_q == '0) ? S_TRAIL : S_FILL;
          end else if (tmr_q == TMR_W'(INIT_LIMIT - 1)) begin
            state_q <= S_ERR;
          end else begin
            tmr_q <= tmr_q + TMR_W'(1);
          end
        end
        S_FILL: begin
          if (byte_valid_i) begin
            rem_q <= rem_q - LEN_W'(1);
            if (fill_q == 2'd3 || rem_q == LEN_W'(1)) begin
              grp_q   <= {1'b0, fill_q} + 3'd1;
              send_q  <= '0;
              state_q <= S_SEND;
            end else begin
              fill_q <= fill_q + 2'd1;
            end
          end
        end
        S_SEND: begin
          if (ser_idle) begin
            send_q <= send_q + 2'd1;
            if (last_in_grp) begin
              fill_q  <= '0;
              tmr_q   <= '0;
              state_q <= (rem_q == '0) ? S_TRAIL : S_FILL;
            end
          end
        end
        S_TRAIL: begin
          if (ser_idle) begin
            if (done_s) begin
              state_q <= S_OK;
            end else if (tmr_q == TMR_W'(DONE_LIMIT)) begin
              state_q <= S_ERR;
            end else begin
              tmr_q <= tmr_q + TMR_W'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign byte_ready_o = (state_q == S_FILL);
  assign pwr_en_o     = pwr_q;
  assign prog_n_o     = (state_q != S_PROG);
  assign busy_o       = (state_q != S_IDLE) && (state_q != S_OK) && (state_q != S_ERR);
  assign ok_o         = (state_q == S_OK);
  assign err_o        = (state_q == S_ERR);

  // R1: no configuration clock outside a load
  p_idle_clk_r1: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> !cclk_o);
  // R2: program pulse only with the target powered
  p_prog_pwr_r2: assert property (@(posedge clk) disable iff (rst)
    !prog_n_o |-> pwr_en_o);
  // R9: trailing pulse counter never passes its limit
  p_trail_bound_r9: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_TRAIL) |-> (tmr_q <= TMR_W'(DONE_LIMIT)));
  // R10: a start during a load leaves the captured mode alone
  p_busy_start_r10: assert property (@(posedge clk) disable iff (rst)
    (busy_o && start_i) |=> $stable(rev_q));
  // R11: error is held until a start arrives
  p_err_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (err_o && !start_i) |=> err_o);
endmodule

// File: tb/test_cfg_loader.sv
`timescale 1ns/1ps
module test_cfg_loader;
  localparam int SETTLE = 4;
  localparam int PROGC  = 6;
  localparam int INITL  = 30;
  localparam int DONEL  = 8;
  localparam int HALF   = 2;
  localparam int LW     = 8;
  localparam int INIT_DLY = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0, rev_i = 1'b0;
  logic [1:0] img_ofs_i = '0;
  logic [LW-1:0] img_len_i = '0;
  logic byte_valid_i;
  logic [7:0] byte_data_i;
  logic byte_ready_o;
  logic init_i = 1'b0, done_i = 1'b0;
  logic pwr_en_o, prog_n_o, cclk_o, din_o, busy_o, ok_o, err_o;

  always #10 clk = ~clk;

  cfg_loader #(.SETTLE_CYC(SETTLE), .PROG_LOW_CYC(PROGC), .INIT_LIMIT(INITL),
               .DONE_LIMIT(DONEL), .HALF_CYC(HALF), .LEN_W(LW)) i_cfg_loader (
    .clk(clk), .rst(rst), .start_i(start_i), .rev_i(rev_i), .img_ofs_i(img_ofs_i),
    .img_len_i(img_len_i), .byte_valid_i(byte_valid_i), .byte_data_i(byte_data_i),
    .byte_ready_o(byte_ready_o), .init_i(init_i), .done_i(done_i),
    .pwr_en_o(pwr_en_o), .prog_n_o(prog_n_o), .cclk_o(cclk_o), .din_o(din_o),
    .busy_o(busy_o), .ok_o(ok_o), .err_o(err_o));

  int errors = 0, checks = 0;

  // byte source
  logic [7:0] src [64];
  int src_n = 0, src_idx = 0;
  assign byte_valid_i = (src_idx < src_n);
  assign byte_data_i  = src[src_idx[5:0]];
  always @(posedge clk) if (byte_valid_i && byte_ready_o) src_idx <= src_idx + 1;

  // target model
  logic [7:0] rx [64];
  logic [7:0] rx_sh = '0;
  int rx_bits = 0, init_cnt = 0, done_after = 0, prog_lo = 0;
  int hi_run = 0, hi_bad = 0;
  bit init_en = 1, done_en = 1, cclk_prev = 0;
  always @(negedge clk) begin
    if (!prog_n_o) begin
      prog_lo++; init_cnt = 0; init_i <= 1'b0; done_i <= 1'b0;
    end else if (init_en && pwr_en_o) begin
      if (init_cnt >= INIT_DLY) init_i <= 1'b1; else init_cnt++;
    end
    if (cclk_o) hi_run++;
    if (cclk_o && !cclk_prev) begin
      rx_sh = {rx_sh[6:0], din_o};
      if (rx_bits % 8 == 7) rx[(rx_bits / 8) % 64] = rx_sh;
      rx_bits++;
    end
    if (!cclk_o && cclk_prev) begin
      if (hi_run != HALF) hi_bad++;
      hi_run = 0;
    end
    if (done_en && done_after > 0 && rx_bits >= done_after) done_i <= 1'b1;
    cclk_prev = cclk_o;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic prep(input int n, input int seed);
    @(negedge clk);
    for (int k = 0; k < n; k++) src[k] = 8'(seed * 37 + k * 73 + 5);
    src_n = n; src_idx = 0; rx_bits = 0; prog_lo = 0; hi_bad = 0;
    done_after = 0;
    init_i = 1'b0; done_i = 1'b0;
  endtask

  task automatic go(input bit rv, input logic [1:0] ofs, input int len);
    @(negedge clk);
    start_i = 1'b1; rev_i = rv; img_ofs_i = ofs; img_len_i = LW'(len);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000 && busy_o; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(!pwr_en_o && prog_n_o && !cclk_o && !din_o, "R1", "idle lines",
        {pwr_en_o, prog_n_o, cclk_o, din_o}, 4'b0100);
    chk(!busy_o && !ok_o && !err_o, "R1", "status", {busy_o, ok_o, err_o}, 0);
  endtask

  task automatic t_natural();
    prep(6, 1);
    done_after = 6 * 8 + 3;
    go(1'b0, 2'd1, 6);
    chk(pwr_en_o && busy_o, "R2", "power on after start", pwr_en_o, 1);
    wait_idle();
    chk(prog_lo == PROGC, "R2", "program low width", prog_lo, PROGC);
    chk(ok_o && !err_o, "R8", "ok after done", ok_o, 1);
    chk(rx_bits >= 51, "R8", "trailing pulses", rx_bits, 51);
    chk(hi_bad == 0, "R4", "half period errors", hi_bad, 0);
    for (int k = 0; k < 6; k++)
      chk(rx[k] == src[k], "R5", $sformatf("natural byte %0d", k), rx[k], src[k]);
  endtask

  task automatic t_reverse();
    prep(8, 2);
    done_after = 64;
    go(1'b1, 2'd0, 8);
    chk(!ok_o, "R11", "ok cleared by start", ok_o, 0);
    wait_idle();
    chk(ok_o, "R8", "ok reversed", ok_o, 1);
    for (int k = 0; k < 8; k++)
      chk(rx[k] == src[k ^ 3], "R6", $sformatf("reversed slot %0d", k), rx[k], src[k ^ 3]);
  endtask

  task automatic t_misalign();
    prep(6, 3);
    go(1'b1, 2'd0, 6);
    repeat (3) @(negedge clk);
    chk(err_o && !busy_o, "R7", "length not whole words", err_o, 1);
    go(1'b1, 2'd2, 8);
    repeat (20) @(negedge clk);
    chk(err_o && src_idx == 0 && rx_bits == 0, "R7", "offset misaligned, nothing sent",
        src_idx + rx_bits, 0);
    chk(err_o && !ok_o, "R11", "error held", err_o, 1);
  endtask

  task automatic t_init_timeout();
    prep(4, 4);
    init_en = 0;
    go(1'b0, 2'd0, 4);
    wait_idle();
    chk(err_o, "R3", "init timeout error", err_o, 1);
    chk(src_idx == 0 && rx_bits == 0, "R3", "nothing taken or sent", src_idx + rx_bits, 0);
    init_en = 1;
  endtask

  task automatic t_done_timeout();
    prep(2, 5);
    done_en = 0;
    go(1'b0, 2'd0, 2);
    wait_idle();
    chk(err_o, "R9", "done timeout error", err_o, 1);
    chk(rx_bits == 16 + DONEL, "R9", "pulse count", rx_bits, 16 + DONEL);
    done_en = 1;
  endtask

  task automatic t_busy_ignore();
    prep(5, 6);
    done_after = 40 + 2;
    go(1'b0, 2'd0, 5);
    repeat (12) @(negedge clk);
    go(1'b1, 2'd1, 7);
    chk(busy_o && !err_o, "R10", "start while busy ignored", busy_o, 1);
    wait_idle();
    chk(ok_o, "R10", "load completes", ok_o, 1);
    for (int k = 0; k < 5; k++)
      chk(rx[k] == src[k], "R10", $sformatf("byte %0d unchanged", k), rx[k], src[k]);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_natural();
    t_reverse();
    t_misalign();
    t_init_timeout();
    t_done_timeout();
    t_busy_ignore();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #3_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule